// File: doc/BRIEF.md
# Level-Gated Zero-Crossing Pulse Output

This block watches two signed sample streams, one for voltage and one for current, and reports each change of polarity between consecutive valid samples as a one-cycle crossing strobe for that channel. Each channel's detector runs only while that channel's peak magnitude is strictly above its own programmable threshold. A small or missing signal therefore cannot produce spurious crossings from noise around zero.

A one-bit selector picks which channel's crossings drive a single digital output. Each selected crossing stretches into a pulse of fixed absolute duration, 250 µs. The duration is counted in clock cycles derived from a clock-frequency parameter, not in sample periods. A crossing that arrives while a pulse is already high restarts the timer, so the pin stays high without a gap. When a channel's gate goes from disabled to enabled, the first valid sample only reloads the stored polarity. A sign held over from before the gate was disabled is never compared.

Top module: `zxp_pulse_out`

## Requirements
- R1: After reset, `pulse_o`, `v_zx_o` and `i_zx_o` are all low.
- R2: Voltage crossings are detected only while |`v_peak_i`| is strictly greater than `v_thresh_i`. When the magnitude equals or is below the threshold, no voltage strobe occurs.
- R3: A crossing is a difference in sign bit (bit W-1) between the current valid sample and the previous valid sample of the same channel. The strobe is high for exactly the one cycle after the clock edge that takes the crossing sample. Sample changes while `sample_vld_i` is low are ignored.
- R4: The current channel follows R2 and R3 independently, using |`i_peak_i`| and `i_thresh_i`.
- R5: Both positive-to-negative and negative-to-positive sign changes count as crossings.
- R6: A strobe on the selected channel raises `pulse_o` one cycle later. The pin then stays high for exactly PULSE_CYC = CLK_HZ/1000*PULSE_US/1000 cycles, which is 1000 cycles for a 4 MHz clock.
- R7: A selected strobe that arrives while the pin is high reloads the full PULSE_CYC count. The pin stays high continuously and falls PULSE_CYC cycles after the last strobe's load.
- R8: `chan_sel_i` = 0 routes voltage strobes to the pin and `chan_sel_i` = 1 routes current strobes. Strobes of the unselected channel never affect the pin.
- R9: The first valid sample after reset, or after a channel's gate turns on again, only loads the stored sign and never produces a strobe.
- R10: Peak magnitude is taken as an unsigned W-bit value. The most negative peak, -2^(W-1), has magnitude 2^(W-1), which exceeds a threshold of 2^(W-1)-1 and equals a threshold of 2^(W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld_i | input | 1 | Both sample inputs carry a new valid sample this cycle |
| v_sample_i | input | SAMPLE_W | Signed voltage sample |
| i_sample_i | input | SAMPLE_W | Signed current sample |
| v_peak_i | input | SAMPLE_W | Signed voltage peak value |
| i_peak_i | input | SAMPLE_W | Signed current peak value |
| v_thresh_i | input | SAMPLE_W | Unsigned voltage gate threshold |
| i_thresh_i | input | SAMPLE_W | Unsigned current gate threshold |
| chan_sel_i | input | 1 | 0 selects voltage, 1 selects current for the pin |
| pulse_o | output | 1 | Stretched crossing pulse |
| v_zx_o | output | 1 | Voltage crossing strobe |
| i_zx_o | output | 1 | Current crossing strobe |

## Verification
The bench sets the peak exactly equal to the threshold, on both channels, to catch a gate that uses greater-or-equal. It uses the most negative peak to catch a magnitude computation that wraps to zero or stays negative. It disables a gate while the samples change sign and then re-enables it, so a design that keeps the stale sign fires a false strobe. It also toggles samples with the valid strobe low to expose a detector that tracks unqualified inputs. On the pin side it measures single-pulse width, a retriggered pulse that must stretch by the gap between strobes rather than split in two, and strobes on the unselected channel that must leave the pin untouched.

// File: rtl/zxp_pkg.sv
`timescale 1ns/1ps
package zxp_pkg;
  localparam int NCH = 2;
  localparam int CH_V = 0;
  localparam int CH_I = 1;

  typedef enum logic [0:0] {
    SEL_VOLT = 1'b0,
    SEL_CURR = 1'b1
  } zxp_sel_e;
endpackage

// File: rtl/zxp_rst_sync.sv
`timescale 1ns/1ps
module zxp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s0_q, s1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_q <= 1'b0;
      s1_q <= 1'b0;
    end else begin
      s0_q <= 1'b1;
      s1_q <= s0_q;
    end
  end

  assign rst_sync_n = s1_q;
endmodule

// File: rtl/zxp_level_gate.sv
`timescale 1ns/1ps
module zxp_level_gate #(
  parameter int W = 24
) (
  input  logic [W-1:0] peak_i,
  input  logic [W-1:0] thresh_i,
  output logic         en_o
);
  logic [W-1:0] mag;

  // Two's-complement magnitude as unsigned; the most negative value maps to 2^(W-1).
  always_comb begin
    if (peak_i[W-1]) mag = ~peak_i + {{(W-1){1'b0}}, 1'b1};
    else             mag = peak_i;
  end

  assign en_o = (mag > thresh_i);
endmodule

// File: rtl/zxp_sign_track.sv
`timescale 1ns/1ps
module zxp_sign_track #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_i,
  input  logic         en_i,
  input  logic [W-1:0] smp_i,
  output logic         zx_o
);
  logic sign;
  logic armed_q, armed_d;
  logic prev_q, prev_d;
  logic zx_q, zx_d;
  logic prev_ce;

  assign sign    = ($signed(smp_i) < 0);
  assign prev_ce = vld_i & en_i;

  always_comb begin
    armed_d = armed_q;
    prev_d  = prev_q;
    zx_d    = 1'b0;
    if (!en_i) begin
      armed_d = 1'b0;
    end else if (vld_i) begin
      zx_d    = armed_q & (sign != prev_q);
      prev_d  = sign;
      armed_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      zx_q    <= 1'b0;
    end else begin
      armed_q <= armed_d;
      zx_q    <= zx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prev_q <= 1'b0;
    else if (prev_ce) prev_q <= prev_d;
  end

  assign zx_o = zx_q;
endmodule

// File: rtl/zxp_pulse_timer.sv
`timescale 1ns/1ps
module zxp_pulse_timer #(
  parameter int CYC = 1000,
  localparam int CW = $clog2(CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pin_o
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy;
  logic          cnt_ce;

  assign busy   = (cnt_q != '0);
  assign cnt_ce = trig_i | busy;

  always_comb begin
    if (trig_i) cnt_d = CW'(CYC);
    else        cnt_d = cnt_q - {{(CW-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign pin_o = busy;
endmodule

// File: rtl/zxp_pulse_out.sv
`timescale 1ns/1ps
module zxp_pulse_out
  import zxp_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CLK_HZ   = 4_000_000,
  parameter int PULSE_US = 250
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sample_vld_i,
  input  logic [SAMPLE_W-1:0] v_sample_i,
  input  logic [SAMPLE_W-1:0] i_sample_i,
  input  logic [SAMPLE_W-1:0] v_peak_i,
  input  logic [SAMPLE_W-1:0] i_peak_i,
  input  logic [SAMPLE_W-1:0] v_thresh_i,
  input  logic [SAMPLE_W-1:0] i_thresh_i,
  input  logic                chan_sel_i,
  output logic                pulse_o,
  output logic                v_zx_o,
  output logic                i_zx_o
);
  localparam int PULSE_CYC = (CLK_HZ / 1000) * PULSE_US / 1000;

  logic                rst_s_n;
  logic [SAMPLE_W-1:0] smp_a [NCH];
  logic [SAMPLE_W-1:0] pk_a  [NCH];
  logic [SAMPLE_W-1:0] th_a  [NCH];
  logic [NCH-1:0]      en_w;
  logic [NCH-1:0]      zx_w;
  logic                trig;

  zxp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign smp_a[CH_V] = v_sample_i;
  assign smp_a[CH_I] = i_sample_i;
  assign pk_a[CH_V]  = v_peak_i;
  assign pk_a[CH_I]  = i_peak_i;
  assign th_a[CH_V]  = v_thresh_i;
  assign th_a[CH_I]  = i_thresh_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    zxp_level_gate #(.W(SAMPLE_W)) u_gate (
      .peak_i   (pk_a[c]),
      .thresh_i (th_a[c]),
      .en_o     (en_w[c])
    );
    zxp_sign_track #(.W(SAMPLE_W)) u_trk (
      .clk   (clk),
      .rst_n (rst_s_n),
      .vld_i (sample_vld_i),
      .en_i  (en_w[c]),
      .smp_i (smp_a[c]),
      .zx_o  (zx_w[c])
    );
  end

  assign trig = (zxp_sel_e'(chan_sel_i) == SEL_CURR) ? zx_w[CH_I] : zx_w[CH_V];

  zxp_pulse_timer #(.CYC(PULSE_CYC)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .trig_i (trig),
    .pin_o  (pulse_o)
  );

  assign v_zx_o = zx_w[CH_V];
  assign i_zx_o = zx_w[CH_I];
endmodule

// File: rtl/zxp_pulse_out_chk.sv
`timescale 1ns/1ps
module zxp_pulse_out_chk #(
  parameter int W = 24,
  parameter int PULSE_CYC = 1000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sample_vld_i,
  input logic [W-1:0] v_peak_i,
  input logic [W-1:0] i_peak_i,
  input logic [W-1:0] v_thresh_i,
  input logic [W-1:0] i_thresh_i,
  input logic         chan_sel_i,
  input logic         pulse_o,
  input logic         v_zx_o,
  input logic         i_zx_o
);
  function automatic logic above(input logic [W-1:0] pk, input logic [W-1:0] th);
    logic [W:0] m;
    m = pk[W-1] ? ({1'b0, ~pk} + 1'b1) : {1'b0, pk};
    return m > {1'b0, th};
  endfunction

  logic        sel_trig;
  logic [31:0] since_q;

  assign sel_trig = chan_sel_i ? i_zx_o : v_zx_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        since_q <= '0;
    else if (sel_trig) since_q <= 32'd1;
    else if (pulse_o)  since_q <= since_q + 32'd1;
    else               since_q <= '0;
  end

  p_gate_v_r2: assert property (@(posedge clk) disable iff (!rst_n)
    v_zx_o |-> $past(sample_vld_i && above(v_peak_i, v_thresh_i)));

  p_gate_i_r4: assert property (@(posedge clk) disable iff (!rst_n)
    i_zx_o |-> $past(sample_vld_i && above(i_peak_i, i_thresh_i)));

  p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (v_zx_o || i_zx_o) |-> $past(sample_vld_i));

  p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pulse_o) |-> $past(sel_trig));

  p_retrig_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sel_trig |=> pulse_o);

  p_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pulse_o) |-> (since_q == 32'(PULSE_CYC + 1)));
endmodule

bind zxp_pulse_out zxp_pulse_out_chk #(.W(SAMPLE_W), .PULSE_CYC(PULSE_CYC)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sample_vld_i (sample_vld_i),
  .v_peak_i     (v_peak_i),
  .i_peak_i     (i_peak_i),
  .v_thresh_i   (v_thresh_i),
  .i_thresh_i   (i_thresh_i),
  .chan_sel_i   (chan_sel_i),
  .pulse_o      (pulse_o),
  .v_zx_o       (v_zx_o),
  .i_zx_o       (i_zx_o)
);

// File: tb/tb_zxp_pulse_out.sv
`timescale 1ns/1ps
module tb_zxp_pulse_out;
  localparam int W  = 24;
  localparam int HZ = 400_000;
  localparam int PW = (HZ / 1000) * 250 / 1000;  // 100 cycles

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld = 1'b0;
  logic [W-1:0] vs = '0, is = '0, vpk = '0, ipk = '0, vth = '0, ith = '0;
  logic         sel = 1'b0;
  logic         pulse, vzx, izx;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  zxp_pulse_out #(.SAMPLE_W(W), .CLK_HZ(HZ), .PULSE_US(250)) dut (
    .clk(clk), .rst_n(rst_n), .sample_vld_i(vld),
    .v_sample_i(vs), .i_sample_i(is), .v_peak_i(vpk), .i_peak_i(ipk),
    .v_thresh_i(vth), .i_thresh_i(ith), .chan_sel_i(sel),
    .pulse_o(pulse), .v_zx_o(vzx), .i_zx_o(izx)
  );

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  function automatic bit gate_on(input logic [W-1:0] pk, input logic [W-1:0] th);
    longint m;
    m = $signed(pk) < 0 ? -longint'($signed(pk)) : longint'($signed(pk));
    return m > longint'({40'd0, th});
  endfunction

  bit m_armed[2], m_prev[2], m_zx[2];
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_armed = '{0, 0}; m_prev = '{0, 0}; m_zx = '{0, 0}; m_cnt = 0;
    end else begin
      bit nzx[2];
      bit en;
      bit sg;
      bit trig;
      trig = sel ? m_zx[1] : m_zx[0];
      for (int c = 0; c < 2; c++) begin
        en = (c == 0) ? gate_on(vpk, vth) : gate_on(ipk, ith);
        sg = (c == 0) ? vs[W-1] : is[W-1];
        nzx[c] = 0;
        if (!en) m_armed[c] = 0;
        else if (vld) begin
          nzx[c] = m_armed[c] && (sg != m_prev[c]);
          m_prev[c] = sg;
          m_armed[c] = 1;
        end
      end
      if (trig) m_cnt = PW;
      else if (m_cnt > 0) m_cnt--;
      m_zx = nzx;
    end
  end

  // Per-cycle comparison and event monitors
  int nzv = 0, nzi = 0, run = 0, last_run = 0, runs = 0;
  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      check("R6 pin vs model", pulse, m_cnt != 0);
      check("R3 v strobe vs model", vzx, m_zx[0]);
      check("R4 i strobe vs model", izx, m_zx[1]);
    end
    if (vzx) nzv++;
    if (izx) nzi++;
    if (pulse) run++;
    else if (run > 0) begin last_run = run; runs++; run = 0; end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input logic [W-1:0] v, input logic [W-1:0] i);
    @(negedge clk);
    vld = 1'b1; vs = v; is = i;
    @(negedge clk);
    vld = 1'b0;
    idle(2);
  endtask

  function automatic logic [W-1:0] sv(input int x);
    return W'(x);
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int b, r;
    vth = 24'd100; ith = 24'd50;
    idle(5);
    check("R1 pin after reset", pulse, 0);
    check("R1 v strobe after reset", vzx, 0);
    check("R1 i strobe after reset", izx, 0);
    rst_n = 1'b1;
    idle(5);
    check("R1 pin after release", pulse, 0);

    // R2: peak equal to threshold keeps the voltage gate closed
    vpk = 24'd100; b = nzv;
    send(sv(5), 0); send(sv(-5), 0); send(sv(5), 0);
    check("R2 equal peak no strobe", nzv - b, 0);

    // R9 + R5 + R3: open gate, first sample loads only
    vpk = 24'd101; idle(2); b = nzv;
    send(sv(5), 0);
    check("R9 first sample after enable", nzv - b, 0);
    send(sv(-5), 0);
    check("R5 pos to neg", nzv - b, 1);
    send(sv(-7), 0);
    check("R3 same sign no strobe", nzv - b, 1);
    send(sv(7), 0);
    check("R5 neg to pos", nzv - b, 2);
    @(negedge clk); vs = sv(-9); idle(3); vs = sv(7); idle(2);
    send(sv(8), 0);
    check("R3 invalid samples ignored", nzv - b, 2);
    idle(150);

    // R6: single pulse width
    send(sv(-5), 0); idle(150);
    check("R6 pulse width", last_run, PW);

    // R7: retrigger during pulse
    @(negedge clk); vld = 1'b1; vs = sv(5);
    @(negedge clk); vld = 1'b0;
    idle(29);
    vld = 1'b1; vs = sv(-5);
    @(negedge clk); vld = 1'b0;
    idle(200);
    check("R7 retriggered run length", last_run, 30 + PW);

    // R4 + R8: current channel, not selected
    ipk = sv(-60); idle(2); b = nzi; r = runs;
    send(sv(-5), sv(5)); send(sv(-5), sv(-5)); send(sv(-5), sv(5));
    idle(150);
    check("R4 current crossings", nzi - b, 2);
    check("R8 unselected current no pulse", runs - r, 0);
    check("R8 pin low", pulse, 0);
    ith = sv(60); b = nzi;
    send(sv(-5), sv(-5));
    check("R4 current equal threshold", nzi - b, 0);
    ith = sv(50);
    send(sv(-5), sv(-5));
    check("R9 current reload after re-enable", nzi - b, 0);

    // R8: select current
    sel = 1'b1; idle(2); r = runs; b = nzv;
    send(sv(5), sv(-5));
    idle(150);
    check("R8 voltage strobe seen", nzv - b, 1);
    check("R8 unselected voltage no pulse", runs - r, 0);
    send(sv(5), sv(5));
    idle(150);
    check("R8 selected current pulse", runs - r, 1);
    check("R8 selected pulse width", last_run, PW);

    // R9 voltage: stale sign after gate off/on
    sel = 1'b0; vpk = 24'd0; b = nzv;
    send(sv(-5), sv(5));
    vpk = 24'd101;
    send(sv(-5), sv(5));
    check("R9 voltage reload no false strobe", nzv - b, 0);
    send(sv(5), sv(5));
    check("R9 crossing after reload", nzv - b, 1);
    idle(150);

    // R10: most negative peak
    @(negedge clk); vpk = 24'h800000; vth = 24'h7FFFFF;
    idle(2); b = nzv;
    send(sv(-5), sv(5));
    check("R10 most negative peak above", nzv - b, 1);
    vth = 24'h800000; b = nzv;
    send(sv(5), sv(5)); send(sv(-5), sv(5));
    check("R10 most negative peak equal", nzv - b, 0);
    idle(150);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule